// File: doc/BRIEF.md
# Serial Host Register Interface

This block is the slave end of a four-wire serial control port placed in front of a small register file. The host supplies a serial clock, a command data line and an active-low select. The block returns a reply data line with its own drive enable. Every transaction opens with an address/command byte. Depending on the code, the command byte is followed by one or two write bytes, by one reply byte shifted back to the host, or by nothing at all. Pulling the select high before the last expected bit abandons the transaction, and no register changes.

The serial clock, select and data lines are synchronised into the system clock domain. The block captures data on rising serial clock edges and advances reply bits on falling edges. It keeps control, interrupt-enable, attenuation, modulation level, receive sync word, transmit data and status registers. From the control bits it produces effective enable outputs, and these obey mutual-exclusion rules. An interrupt pull-down request is raised whenever a status bit and its matching enable bit are both set. A completed status read clears the bits it reported.

Top module: `host_reg_port`

## Requirements
- R1: Bytes are shifted MSB first, one bit per rising edge of `sclk_i`. The first byte of each transaction, opened by `csn_i` falling, is the command code.
- R2: The write commands and their lengths are:
  - 0x10: control 1, one byte.
  - 0x11: control 2, one byte.
  - 0x13: interrupt enable, one byte.
  - 0x14: attenuation, one byte.
  - 0x15: transmit data, one byte.
  - 0x12: modulation level, two bytes.
  - 0x44: receive sync word, two bytes.

  For a two-byte write, the first data byte is bits 15:8.
- R3: If `csn_i` rises before the last bit of a transaction, no register changes.
- R4: Command 0x80 returns the status byte and command 0x81 returns `rx_data_i`, MSB first. Bit 7 is presented after the eighth command rising edge, and each later bit after each falling edge. `reply_oe_o` is high only until the eighth reply rising edge.
- R5: Command 0x01 has no data. It clears control 1, control 2, interrupt enable, attenuation, modulation level and status. It leaves the receive sync word and transmit data unchanged.
- R6: A high bit on `status_set_i` sets the matching status bit. A completed 0x80 read clears only the bits it reported; an aborted read clears nothing. `irq_pull_o` is 1 exactly while status AND interrupt-enable is nonzero.
- R7: Control 1 bit map: bit 7 amplifier 1, bit 6 amplifier 2 and second modulator, bit 5 audio filter, bit 4 FFSK receive, bit 3 FFSK transmit, bit 2 sync standard select. Control 2 bit 4 is tone encoder enable, and bits 3:0 are the tone code.
- R8: The effective FFSK receive enable is bit 4 AND NOT bit 3. The effective FFSK transmit enable is bit 3 AND NOT bit 4 AND NOT the tone bit. The effective tone enable is the tone bit AND NOT bit 3.
- R9: Unknown command codes, with any bytes after them, change nothing. Bits sent after a transaction completes are ignored.
- R10: `tx_load_o` pulses for exactly one cycle for each completed 0x15 write.
- R11: After `rst_ni` the following are all zero: every register, `irq_pull_o`, `reply_oe_o` and every enable output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock |
| sdi_i | input | 1 | Host command data |
| csn_i | input | 1 | Host select, active low |
| reply_d_o | output | 1 | Reply data bit |
| reply_oe_o | output | 1 | Reply drive enable (line released when 0) |
| irq_pull_o | output | 1 | Interrupt pull-down request (open-drain, low when 1) |
| status_set_i | input | 8 | Status bit set pulses |
| rx_data_i | input | 8 | Receive data returned by command 0x81 |
| amp1_en_o | output | 1 | Amplifier 1 enable |
| amp2_en_o | output | 1 | Amplifier 2 and second modulator enable |
| audio_en_o | output | 1 | Audio filter enable |
| ffsk_rx_en_o | output | 1 | Effective FFSK receive enable |
| ffsk_tx_en_o | output | 1 | Effective FFSK transmit enable |
| tone_en_o | output | 1 | Effective tone encoder enable |
| sync_std_o | output | 1 | Sync standard select |
| tone_code_o | output | 4 | Tone code |
| atten_o | output | 8 | Attenuation register |
| mod_level_o | output | 16 | Modulation level register |
| rx_sync_o | output | 16 | Receive sync word register |
| tx_data_o | output | 8 | Transmit data register |
| tx_load_o | output | 1 | Transmit data write strobe |

## Verification
The bench sweeps all 256 control 1 values with the tone bit both clear and set, so that every exclusion combination is visited. A design that forced only one of a conflicting pair off would fail on the codes with bits 3 and 4 both set, or with bit 3 and the tone bit both set. Transactions are cut off midway through the command byte, within and after the first data byte, and within a status read. A design that committed bytes early, or cleared status on a partial read, would show changed registers or lost status bits. The reset command is checked to spare the sync word and transmit data, and unknown codes and trailing bytes are checked to leave every register alone.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam int STAT_W = 8;

  localparam logic [7:0] CMD_RESET   = 8'h01;
  localparam logic [7:0] CMD_CTRL1   = 8'h10;
  localparam logic [7:0] CMD_CTRL2   = 8'h11;
  localparam logic [7:0] CMD_MOD     = 8'h12;
  localparam logic [7:0] CMD_IRQEN   = 8'h13;
  localparam logic [7:0] CMD_ATTEN   = 8'h14;
  localparam logic [7:0] CMD_TXDATA  = 8'h15;
  localparam logic [7:0] CMD_RXSYNC  = 8'h44;
  localparam logic [7:0] CMD_RD_STAT = 8'h80;
  localparam logic [7:0] CMD_RD_RXD  = 8'h81;

  typedef enum logic [2:0] {K_NONE, K_RESET, K_WR1, K_WR2, K_RD} cmd_kind_e;

  function automatic cmd_kind_e cmd_kind(input logic [7:0] c);
    case (c)
      CMD_RESET:                                              return K_RESET;
      CMD_CTRL1, CMD_CTRL2, CMD_IRQEN, CMD_ATTEN, CMD_TXDATA: return K_WR1;
      CMD_MOD, CMD_RXSYNC:                                    return K_WR2;
      CMD_RD_STAT, CMD_RD_RXD:                                return K_RD;
      default:                                                return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
  parameter int         W       = 1,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe <= {STAGES{RST_VAL}};
    else         pipe <= {pipe[STAGES-2:0], d_i};
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/hrp_frame.sv
module hrp_frame
  import hrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              sdi_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [7:0]        rxd_i,
  output logic              wr_o,
  output logic [7:0]        wr_cmd_o,
  output logic [15:0]       wr_data_o,
  output logic              rst_cmd_o,
  output logic              rd_done_o,
  output logic              rd_status_o,
  output logic [7:0]        rd_mask_o,
  output logic              reply_d_o,
  output logic              reply_oe_o
);
  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_REPLY, S_HOLD} state_e;

  state_e      state;
  logic [3:0]  cnt;
  logic [15:0] sh;
  logic [7:0]  cmd_q;
  logic        two_q;
  logic [7:0]  reply_q;
  logic [2:0]  idx;
  logic [7:0]  cmd_now;
  logic [15:0] sh_now;
  logic [3:0]  last;

  assign sh_now  = {sh[14:0], sdi_i};
  assign cmd_now = sh_now[7:0];
  assign last    = two_q ? 4'd15 : 4'd7;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= S_IDLE;
      cnt         <= '0;
      sh          <= '0;
      cmd_q       <= '0;
      two_q       <= 1'b0;
      reply_q     <= '0;
      idx         <= '0;
      wr_o        <= 1'b0;
      wr_cmd_o    <= '0;
      wr_data_o   <= '0;
      rst_cmd_o   <= 1'b0;
      rd_done_o   <= 1'b0;
      rd_status_o <= 1'b0;
    end else begin
      wr_o      <= 1'b0;
      rst_cmd_o <= 1'b0;
      rd_done_o <= 1'b0;
      if (!cs_act_i) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: begin
            state <= S_CMD;
            cnt   <= '0;
          end
          S_CMD: if (sck_rise_i) begin
            sh  <= sh_now;
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cmd_q <= cmd_now;
              cnt   <= '0;
              case (cmd_kind(cmd_now))
                K_RESET: begin rst_cmd_o <= 1'b1; state <= S_HOLD; end
                K_WR1:   begin two_q <= 1'b0; state <= S_DATA; end
                K_WR2:   begin two_q <= 1'b1; state <= S_DATA; end
                K_RD: begin
                  rd_status_o <= (cmd_now == CMD_RD_STAT);
                  reply_q     <= (cmd_now == CMD_RD_STAT) ? status_i : rxd_i;
                  idx         <= '0;
                  state       <= S_REPLY;
                end
                default: state <= S_HOLD;
              endcase
            end
          end
          S_DATA: if (sck_rise_i) begin
            sh  <= sh_now;
            cnt <= cnt + 4'd1;
            if (cnt == last) begin
              wr_o      <= 1'b1;
              wr_cmd_o  <= cmd_q;
              wr_data_o <= two_q ? sh_now : {8'h00, sh_now[7:0]};
              state     <= S_HOLD;
            end
          end
          S_REPLY: begin
            if (sck_rise_i) begin
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                rd_done_o <= 1'b1;
                state     <= S_HOLD;
              end
            end
            if (sck_fall_i) idx <= cnt[2:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_mask_o  = reply_q;
  assign reply_d_o  = reply_q[3'd7 - idx];
  assign reply_oe_o = (state == S_REPLY) && cs_act_i;
endmodule

// File: rtl/hrp_regs.sv
module hrp_regs
  import hrp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [7:0]        wr_cmd_i,
  input  logic [15:0]       wr_data_i,
  input  logic              rst_cmd_i,
  input  logic              rd_done_i,
  input  logic              rd_status_i,
  input  logic [STAT_W-1:0] rd_mask_i,
  input  logic [STAT_W-1:0] status_set_i,
  output logic [7:2]        ctrl1_o,
  output logic [4:0]        ctrl2_o,
  output logic [STAT_W-1:0] irq_en_o,
  output logic [7:0]        atten_o,
  output logic [15:0]       mod_o,
  output logic [15:0]       rxsync_o,
  output logic [7:0]        txdata_o,
  output logic              tx_load_o,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] clr;
  assign clr = (rd_done_i && rd_status_i) ? rd_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl1_o   <= '0;
      ctrl2_o   <= '0;
      irq_en_o  <= '0;
      atten_o   <= '0;
      mod_o     <= '0;
      rxsync_o  <= '0;
      txdata_o  <= '0;
      tx_load_o <= 1'b0;
      status_o  <= '0;
    end else begin
      tx_load_o <= 1'b0;
      if (rst_cmd_i) begin
        ctrl1_o  <= '0;
        ctrl2_o  <= '0;
        irq_en_o <= '0;
        atten_o  <= '0;
        mod_o    <= '0;
        status_o <= '0;
      end else begin
        status_o <= (status_o & ~clr) | status_set_i;
        if (wr_i) begin
          case (wr_cmd_i)
            CMD_CTRL1:  ctrl1_o  <= wr_data_i[7:2];
            CMD_CTRL2:  ctrl2_o  <= wr_data_i[4:0];
            CMD_IRQEN:  irq_en_o <= wr_data_i[STAT_W-1:0];
            CMD_ATTEN:  atten_o  <= wr_data_i[7:0];
            CMD_MOD:    mod_o    <= wr_data_i;
            CMD_RXSYNC: rxsync_o <= wr_data_i;
            CMD_TXDATA: begin
              txdata_o  <= wr_data_i[7:0];
              tx_load_o <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hrp_enables.sv
module hrp_enables
  import hrp_pkg::*;
(
  input  logic [7:2]        ctrl1_i,
  input  logic              tone_req_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic [STAT_W-1:0] irq_en_i,
  output logic              amp1_en_o,
  output logic              amp2_en_o,
  output logic              audio_en_o,
  output logic              ffsk_rx_en_o,
  output logic              ffsk_tx_en_o,
  output logic              tone_en_o,
  output logic              sync_std_o,
  output logic              irq_pull_o
);
  logic rx_req, tx_req;
  assign rx_req = ctrl1_i[4];
  assign tx_req = ctrl1_i[3];

  assign amp1_en_o    = ctrl1_i[7];
  assign amp2_en_o    = ctrl1_i[6];
  assign audio_en_o   = ctrl1_i[5];
  assign sync_std_o   = ctrl1_i[2];
  // conflicting requests cancel each other pairwise
  assign ffsk_rx_en_o = rx_req & ~tx_req;
  assign ffsk_tx_en_o = tx_req & ~rx_req & ~tone_req_i;
  assign tone_en_o    = tone_req_i & ~tx_req;
  assign irq_pull_o   = |(status_i & irq_en_i);
endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              csn_i,
  output logic              reply_d_o,
  output logic              reply_oe_o,
  output logic              irq_pull_o,
  input  logic [STAT_W-1:0] status_set_i,
  input  logic [7:0]        rx_data_i,
  output logic              amp1_en_o,
  output logic              amp2_en_o,
  output logic              audio_en_o,
  output logic              ffsk_rx_en_o,
  output logic              ffsk_tx_en_o,
  output logic              tone_en_o,
  output logic              sync_std_o,
  output logic [3:0]        tone_code_o,
  output logic [7:0]        atten_o,
  output logic [15:0]       mod_level_o,
  output logic [15:0]       rx_sync_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_load_o
);
  logic [2:0] sync_q;
  logic       sck_s, sck_d, sdi_s, cs_act, sck_rise, sck_fall;

  hrp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({csn_i, sclk_i, sdi_i}), .q_o(sync_q)
  );

  assign cs_act = ~sync_q[2];
  assign sck_s  = sync_q[1];
  assign sdi_s  = sync_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  logic              wr, rst_cmd, rd_done, rd_status;
  logic [7:0]        wr_cmd, rd_mask;
  logic [15:0]       wr_data;
  logic [STAT_W-1:0] status, irq_en;
  logic [7:2]        ctrl1;
  logic [4:0]        ctrl2;

  hrp_frame u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_act_i(cs_act),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sdi_i(sdi_s),
    .status_i(status), .rxd_i(rx_data_i),
    .wr_o(wr), .wr_cmd_o(wr_cmd), .wr_data_o(wr_data), .rst_cmd_o(rst_cmd),
    .rd_done_o(rd_done), .rd_status_o(rd_status), .rd_mask_o(rd_mask),
    .reply_d_o(reply_d_o), .reply_oe_o(reply_oe_o)
  );

  hrp_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_i(wr), .wr_cmd_i(wr_cmd), .wr_data_i(wr_data), .rst_cmd_i(rst_cmd),
    .rd_done_i(rd_done), .rd_status_i(rd_status), .rd_mask_i(rd_mask),
    .status_set_i(status_set_i),
    .ctrl1_o(ctrl1), .ctrl2_o(ctrl2), .irq_en_o(irq_en), .atten_o(atten_o),
    .mod_o(mod_level_o), .rxsync_o(rx_sync_o), .txdata_o(tx_data_o),
    .tx_load_o(tx_load_o), .status_o(status)
  );

  assign tone_code_o = ctrl2[3:0];

  hrp_enables u_en (
    .ctrl1_i(ctrl1), .tone_req_i(ctrl2[4]), .status_i(status), .irq_en_i(irq_en),
    .amp1_en_o(amp1_en_o), .amp2_en_o(amp2_en_o), .audio_en_o(audio_en_o),
    .ffsk_rx_en_o(ffsk_rx_en_o), .ffsk_tx_en_o(ffsk_tx_en_o),
    .tone_en_o(tone_en_o), .sync_std_o(sync_std_o), .irq_pull_o(irq_pull_o)
  );
endmodule

// File: rtl/hrp_checker.sv
module hrp_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sck_rise,
  input logic        wr,
  input logic        rst_cmd,
  input logic        reply_oe_o,
  input logic        irq_pull_o,
  input logic [7:0]  status_set_i,
  input logic        ffsk_rx_en_o,
  input logic        ffsk_tx_en_o,
  input logic        tone_en_o,
  input logic [7:0]  atten_o,
  input logic [15:0] mod_level_o,
  input logic [15:0] rx_sync_o
);
  // R4: reply drive starts only right after a serial rising edge
  a_r4_oe_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(reply_oe_o) |-> $past(sck_rise));

  // R3: registers move only on a completed write or reset command
  a_r3_mod_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mod_level_o) |-> $past(wr || rst_cmd));
  a_r3_sync_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_sync_o) |-> $past(wr));

  // R5: reset command clears levels and interrupt
  a_r5_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_cmd |=> (mod_level_o == 16'h0 && atten_o == 8'h0 && !irq_pull_o));

  // R6: interrupt rises only after a status set or an enable write
  a_r6_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_pull_o) |-> ($past(status_set_i) != 8'h0 || $past(wr)));

  // R8: mutual exclusion
  a_r8_rx_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ffsk_rx_en_o && ffsk_tx_en_o));
  a_r8_tone_tx_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tone_en_o && ffsk_tx_en_o));
endmodule

bind host_reg_port hrp_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sck_rise(sck_rise), .wr(wr), .rst_cmd(rst_cmd),
  .reply_oe_o(reply_oe_o), .irq_pull_o(irq_pull_o), .status_set_i(status_set_i),
  .ffsk_rx_en_o(ffsk_rx_en_o), .ffsk_tx_en_o(ffsk_tx_en_o), .tone_en_o(tone_en_o),
  .atten_o(atten_o), .mod_level_o(mod_level_o), .rx_sync_o(rx_sync_o)
);

// File: tb/tb_host_reg_port.sv
module tb_host_reg_port;
  localparam int HP = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, csn = 1'b1;
  logic [7:0] status_set = '0, rx_data = '0;
  logic reply_d, reply_oe, irq_pull;
  logic amp1, amp2, audio, frx, ftx, tone, sstd, tx_load;
  logic [3:0] tone_code;
  logic [7:0] atten, tx_data;
  logic [15:0] mod_level, rx_sync;

  int checks = 0, failures = 0, tx_loads = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  host_reg_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdi_i(sdi), .csn_i(csn),
    .reply_d_o(reply_d), .reply_oe_o(reply_oe), .irq_pull_o(irq_pull),
    .status_set_i(status_set), .rx_data_i(rx_data),
    .amp1_en_o(amp1), .amp2_en_o(amp2), .audio_en_o(audio),
    .ffsk_rx_en_o(frx), .ffsk_tx_en_o(ftx), .tone_en_o(tone), .sync_std_o(sstd),
    .tone_code_o(tone_code), .atten_o(atten), .mod_level_o(mod_level),
    .rx_sync_o(rx_sync), .tx_data_o(tx_data), .tx_load_o(tx_load)
  );

  always @(posedge clk) if (tx_load) tx_loads++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_lo();
    csn = 1'b0; wait_n(HP);
  endtask

  task automatic cs_hi();
    wait_n(HP); csn = 1'b1; wait_n(8);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdi = b[i]; wait_n(HP);
      sclk = 1'b1; wait_n(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    put_bits(b, 8);
  endtask

  task automatic get_bits(output logic [7:0] r, input int n, output int oe_bad);
    r = '0; oe_bad = 0;
    for (int i = 7; i > 7 - n; i--) begin
      wait_n(HP);
      r[i] = reply_d;
      if (reply_oe !== 1'b1) oe_bad++;
      sclk = 1'b1; wait_n(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic wr1(input logic [7:0] c, input logic [7:0] d);
    cs_lo(); put_byte(c); put_byte(d); cs_hi();
  endtask

  task automatic wr2(input logic [7:0] c, input logic [15:0] d);
    cs_lo(); put_byte(c); put_byte(d[15:8]); put_byte(d[7:0]); cs_hi();
  endtask

  task automatic rd(input logic [7:0] c, output logic [7:0] r, output int oe_bad);
    cs_lo(); put_byte(c); get_bits(r, 8, oe_bad); wait_n(2);
    if (reply_oe !== 1'b0) oe_bad++;
    cs_hi();
  endtask

  task automatic pulse_status(input logic [7:0] s);
    status_set = s; wait_n(1); status_set = '0; wait_n(2);
  endtask

  function automatic logic [6:0] exp_en(input logic [7:0] c, input logic t);
    return {c[7], c[6], c[5], c[4] & ~c[3], c[3] & ~c[4] & ~t, t & ~c[3], c[2]};
  endfunction

  initial begin
    logic [7:0] r;
    int oe_bad;
    wait_n(3); rst_ni = 1'b1; wait_n(3);

    // R11 reset state
    chk("R11 enables", {amp1, amp2, audio, frx, ftx, tone, sstd}, 0);
    chk("R11 regs", {mod_level, atten, tx_data}, 0);
    chk("R11 sync", rx_sync, 0);
    chk("R11 irq/oe", {irq_pull, reply_oe}, 0);

    // R1 R2 writes
    wr2(8'h44, 16'h1234);
    chk("R2 rx sync high byte first", rx_sync, 16'h1234);
    wr2(8'h12, 16'hA55A);
    chk("R1 mod level msb first", mod_level, 16'hA55A);
    wr1(8'h14, 8'h3C);
    chk("R2 atten", atten, 8'h3C);
    wr1(8'h15, 8'hC3);
    chk("R10 tx data", tx_data, 8'hC3);
    chk("R10 tx load single pulse", tx_loads, 1);
    chk("R4 oe off after writes", reply_oe, 0);

    // R3 aborts
    cs_lo(); put_byte(8'h12); put_bits(8'h00, 4); cs_hi();
    chk("R3 abort in first data byte", mod_level, 16'hA55A);
    cs_lo(); put_byte(8'h12); put_byte(8'h00); cs_hi();
    chk("R3 abort after first data byte", mod_level, 16'hA55A);
    cs_lo(); put_byte(8'h44); put_byte(8'hFF); put_bits(8'hFF, 7); cs_hi();
    chk("R3 abort at last bit", rx_sync, 16'h1234);
    cs_lo(); put_bits(8'h14, 5); cs_hi();
    wr1(8'h14, 8'h55);
    chk("R3 recovery after abort in command", atten, 8'h55);
    cs_lo(); put_byte(8'h15); put_bits(8'h00, 6); cs_hi();
    chk("R10 aborted tx write no load", tx_loads, 1);

    // R9 unknown command, trailing bytes
    wr1(8'h77, 8'hFF);
    chk("R9 unknown cmd regs", {mod_level, atten, tx_data}, {16'hA55A, 8'h55, 8'hC3});
    chk("R9 unknown cmd enables", {amp1, amp2, audio, frx, ftx, tone, sstd}, 0);
    cs_lo(); put_byte(8'h14); put_byte(8'h81); put_byte(8'h7F); cs_hi();
    chk("R9 trailing byte ignored", atten, 8'h81);

    // R4 receive data read
    rx_data = 8'h96;
    rd(8'h81, r, oe_bad);
    chk("R4 rx data reply", r, 8'h96);
    chk("R4 oe only during reply", oe_bad, 0);
    rx_data = 8'h3B;
    rd(8'h81, r, oe_bad);
    chk("R4 rx data reply 2", r, 8'h3B);

    // R6 status and interrupt
    wr1(8'h13, 8'h04);
    pulse_status(8'h05);
    chk("R6 irq asserted", irq_pull, 1);
    rd(8'h80, r, oe_bad);
    chk("R6 status read", r, 8'h05);
    chk("R6 irq cleared by read", irq_pull, 0);
    rd(8'h80, r, oe_bad);
    chk("R6 status empty after read", r, 8'h00);
    pulse_status(8'h02);
    chk("R6 masked bit no irq", irq_pull, 0);
    cs_lo(); put_byte(8'h80); get_bits(r, 4, oe_bad); cs_hi();
    rd(8'h80, r, oe_bad);
    chk("R6 aborted read keeps status", r, 8'h02);

    // R7 R8 sweep
    for (int t = 0; t < 2; t++) begin
      wr1(8'h11, {3'b000, t[0], 4'hA});
      chk("R7 tone code", tone_code, 4'hA);
      for (int c = 0; c < 256; c++) begin
        wr1(8'h10, c[7:0]);
        chk("R7 R8 enables", {amp1, amp2, audio, frx, ftx, tone, sstd}, exp_en(c[7:0], t[0]));
      end
    end

    // R5 reset command
    wr1(8'h13, 8'h01);
    pulse_status(8'h01);
    chk("R6 irq before reset cmd", irq_pull, 1);
    cs_lo(); put_byte(8'h01); cs_hi();
    chk("R5 cleared regs", {mod_level, atten, 4'h0, tone_code}, 0);
    chk("R5 cleared enables and irq", {amp1, amp2, audio, frx, ftx, tone, sstd, irq_pull}, 0);
    chk("R5 sync and tx data kept", {rx_sync, tx_data}, {16'h1234, 8'hC3});
    rd(8'h80, r, oe_bad);
    chk("R5 status cleared", r, 8'h00);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule